// File: doc/BRIEF.md
# Event Vector Queue Dispatcher

This block sits beside a small processor core and replaces interrupts with run-to-completion dispatch. The core sits halted until the block offers it a restart address. The core accepts the address and runs the handler at that address until the handler ends. It then signals done, and the block offers the next queued address. The block never diverts a running handler. Arrivals are only recorded, and they wait their turn in time order. There are no priority levels.

Each event source has three pieces of state: a jump vector register that the core writes, an armed flag that a wait instruction sets, and a keep option. The keep option chooses whether the source stays armed after it fires or disarms after one event. When an armed source fires, the block captures that source's vector into the queue. A source can hold at most one entry in the queue, so a queue as deep as the number of slots can never overflow. One extra slot, placed after all sources, carries the reset event. Loading the core queues this event, and so does a reset request from another core. Its vector is the boot address.

The dispatch address leaves the block on a valid/ready pair. `disp_valid_o` is high only while the core is halted and the queue holds an entry. While `disp_valid_o` is high and `disp_ready_i` is low, the offer and its address hold steady. `disp_ready_i` has no effect while `disp_valid_o` is low. A handshake pops the head entry and starts the run.

Top module: `evq_dispatch`

## Requirements
- R1: After reset, and after any later reset, `run_o` and `disp_valid_o` are low, the queue is empty, and every source is disarmed, so events are ignored until a source is armed again.
- R2: A pulse on `load_i` or `rst_req_i` queues the reset slot, whose index is NSRC, with `boot_addr_i` as its vector. If that slot is already pending, the request is dropped.
- R3: A pulse on `evt_i[s]` while source s is armed and not pending pushes the current value of that source's vector register. Pulses on unarmed sources are ignored.
- R4: Each slot holds at most one queued entry. An occurrence while the slot is pending is dropped and does not change the slot's armed state.
- R5: Entries leave the queue in arrival order. Pushes in the same cycle are ordered by ascending slot index, with the reset slot after every source.
- R6: `disp_valid_o` is high only while the core is halted and the queue is non-empty, and `disp_addr_o` shows the head vector. A handshake (valid and ready both high at a clock edge) pops the head and sets `run_o` from the next cycle on. While valid is high and ready is low, the offer and the address stay stable.
- R7: `run_o` stays high until `done_i` is seen. Events that arrive during a run are queued and do not end the run. `done_i` while halted has no effect.
- R8: A slot's pending state clears when its entry is popped, so that source can queue again while its own handler is running.
- R9: Arming source s (`arm_i` with `arm_sel_i`=s) stores `arm_keep_i`. With keep=1 the source stays armed after it fires. With keep=0 it disarms after its first accepted event.
- R10: The queue depth is NSRC+1, and it holds all slots at once without loss.
- R11: A queued entry keeps the vector captured at push time. A later write to the vector register affects only later pushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | One-cycle occurrence pulse per source |
| vec_we_i | input | 1 | Vector register write strobe |
| vec_sel_i | input | SW | Source whose vector is written |
| vec_data_i | input | AW | Vector value to write |
| arm_i | input | 1 | Arm strobe from a wait instruction |
| arm_sel_i | input | SW | Source to arm |
| arm_keep_i | input | 1 | 1 = stay armed after firing, 0 = one-shot |
| load_i | input | 1 | Core load pulse; queues the reset event |
| rst_req_i | input | 1 | Reset event requested by another core |
| boot_addr_i | input | AW | Program start address used by the reset event |
| done_i | input | 1 | Handler finished; core halts |
| disp_valid_o | output | 1 | A restart address is offered |
| disp_ready_i | input | 1 | Core accepts the offered address |
| disp_addr_o | output | AW | Restart address at queue head |
| run_o | output | 1 | Core is running a handler |

## Verification
The bench builds the block with its defaults, NSRC=4 and AW=12. This gives five queue slots, so one cycle that fires every source and a reset request fills the queue completely. That cycle shows the full-depth case and the ordering of simultaneous pushes. Four sources are enough to run keep and one-shot sources side by side, to hit a duplicate while a source is pending, and to queue a source again inside its own handler. Twelve-bit vectors keep the addresses of all slots distinct, so a wrong dequeue order shows up directly at `disp_addr_o`.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic {
    CORE_HALTED  = 1'b0,
    CORE_RUNNING = 1'b1
  } core_st_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/evq_src_ctrl.sv
module evq_src_ctrl #(
  parameter int NSRC = 4,
  parameter int AW   = 12,
  localparam int D   = NSRC + 1,
  localparam int SW  = evq_pkg::idx_bits(NSRC),
  localparam int IW  = evq_pkg::idx_bits(D)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       evt_i,
  input  logic                  vec_we_i,
  input  logic [SW-1:0]         vec_sel_i,
  input  logic [AW-1:0]         vec_data_i,
  input  logic                  arm_i,
  input  logic [SW-1:0]         arm_sel_i,
  input  logic                  arm_keep_i,
  input  logic                  load_i,
  input  logic                  rst_req_i,
  input  logic [AW-1:0]         boot_addr_i,
  input  logic                  pop_i,
  input  logic [IW-1:0]         pop_slot_i,
  output logic [D-1:0]          push_o,
  output logic [D-1:0][AW-1:0]  push_addr_o,
  output logic [D-1:0]          pend_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [AW-1:0] vec_q;
    logic          armed_q, keep_q, pend_q, fire;

    assign fire = armed_q && evt_i[g] && !pend_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_q   <= '0;
        armed_q <= 1'b0;
        keep_q  <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        if (vec_we_i && vec_sel_i == SW'(g)) vec_q <= vec_data_i;
        if (arm_i && arm_sel_i == SW'(g)) begin
          armed_q <= 1'b1;
          keep_q  <= arm_keep_i;
        end else if (fire && !keep_q) begin
          armed_q <= 1'b0;
        end
        if (fire) pend_q <= 1'b1;
        else if (pop_i && pop_slot_i == IW'(g)) pend_q <= 1'b0;
      end
    end

    assign push_o[g]      = fire;
    assign push_addr_o[g] = vec_q;
    assign pend_o[g]      = pend_q;
  end

  logic boot_pend_q, boot_fire;
  assign boot_fire = (load_i || rst_req_i) && !boot_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) boot_pend_q <= 1'b0;
    else if (boot_fire) boot_pend_q <= 1'b1;
    else if (pop_i && pop_slot_i == IW'(NSRC)) boot_pend_q <= 1'b0;
  end

  assign push_o[NSRC]      = boot_fire;
  assign push_addr_o[NSRC] = boot_addr_i;
  assign pend_o[NSRC]      = boot_pend_q;
endmodule

// File: rtl/evq_queue.sv
module evq_queue #(
  parameter int D  = 5,
  parameter int AW = 12,
  localparam int IW = evq_pkg::idx_bits(D),
  localparam int CW = $clog2(D + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [D-1:0]          push_i,
  input  logic [D-1:0][AW-1:0]  push_addr_i,
  input  logic                  pop_i,
  output logic [AW-1:0]         head_addr_o,
  output logic [IW-1:0]         head_slot_o,
  output logic [CW-1:0]         fill_o,
  output logic                  empty_o
);
  logic [AW-1:0] addr_q [D];
  logic [IW-1:0] slot_q [D];
  logic [AW-1:0] addr_n [D];
  logic [IW-1:0] slot_n [D];
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    addr_n = addr_q;
    slot_n = slot_q;
    cnt_n  = cnt_q;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < D - 1; i++) begin
        addr_n[i] = addr_q[i+1];
        slot_n[i] = slot_q[i+1];
      end
      cnt_n = cnt_q - CW'(1);
    end
    for (int s = 0; s < D; s++) begin
      if (push_i[s] && cnt_n < CW'(D)) begin
        addr_n[cnt_n[IW-1:0]] = push_addr_i[s];
        slot_n[cnt_n[IW-1:0]] = IW'(s);
        cnt_n = cnt_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < D; i++) begin
        addr_q[i] <= '0;
        slot_q[i] <= '0;
      end
    end else begin
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      slot_q <= slot_n;
    end
  end

  assign head_addr_o = addr_q[0];
  assign head_slot_o = slot_q[0];
  assign fill_o      = cnt_q;
  assign empty_o     = (cnt_q == '0);
endmodule

// File: rtl/evq_run_ctrl.sv
module evq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic queue_empty_i,
  input  logic disp_ready_i,
  input  logic done_i,
  output logic disp_valid_o,
  output logic pop_o,
  output logic run_o
);
  import evq_pkg::*;
  core_st_e st_q;

  assign disp_valid_o = (st_q == CORE_HALTED) && !queue_empty_i;
  assign pop_o        = disp_valid_o && disp_ready_i;
  assign run_o        = (st_q == CORE_RUNNING);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= CORE_HALTED;
    else begin
      case (st_q)
        CORE_HALTED:  if (pop_o)  st_q <= CORE_RUNNING;
        CORE_RUNNING: if (done_i) st_q <= CORE_HALTED;
        default:                  st_q <= CORE_HALTED;
      endcase
    end
  end
endmodule

// File: rtl/evq_dispatch.sv
module evq_dispatch #(
  parameter int NSRC = 4,
  parameter int AW   = 12,
  localparam int SW  = evq_pkg::idx_bits(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            vec_we_i,
  input  logic [SW-1:0]   vec_sel_i,
  input  logic [AW-1:0]   vec_data_i,
  input  logic            arm_i,
  input  logic [SW-1:0]   arm_sel_i,
  input  logic            arm_keep_i,
  input  logic            load_i,
  input  logic            rst_req_i,
  input  logic [AW-1:0]   boot_addr_i,
  input  logic            done_i,
  output logic            disp_valid_o,
  input  logic            disp_ready_i,
  output logic [AW-1:0]   disp_addr_o,
  output logic            run_o
);
  localparam int D  = NSRC + 1;
  localparam int IW = evq_pkg::idx_bits(D);
  localparam int CW = $clog2(D + 1);

  logic [D-1:0]         push;
  logic [D-1:0][AW-1:0] push_addr;
  logic [D-1:0]         pend;
  logic [IW-1:0]        head_slot;
  logic [CW-1:0]        fill;
  logic                 empty, pop;

  evq_src_ctrl #(.NSRC(NSRC), .AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .vec_we_i(vec_we_i), .vec_sel_i(vec_sel_i), .vec_data_i(vec_data_i),
    .arm_i(arm_i), .arm_sel_i(arm_sel_i), .arm_keep_i(arm_keep_i),
    .load_i(load_i), .rst_req_i(rst_req_i), .boot_addr_i(boot_addr_i),
    .pop_i(pop), .pop_slot_i(head_slot),
    .push_o(push), .push_addr_o(push_addr), .pend_o(pend)
  );

  evq_queue #(.D(D), .AW(AW)) u_q (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_addr_i(push_addr),
    .pop_i(pop), .head_addr_o(disp_addr_o), .head_slot_o(head_slot),
    .fill_o(fill), .empty_o(empty)
  );

  evq_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .queue_empty_i(empty),
    .disp_ready_i(disp_ready_i), .done_i(done_i),
    .disp_valid_o(disp_valid_o), .pop_o(pop), .run_o(run_o)
  );
endmodule

// File: rtl/evq_dispatch_chk.sv
module evq_dispatch_chk #(
  parameter int NSRC = 4,
  parameter int AW   = 12,
  localparam int D   = NSRC + 1,
  localparam int CW  = $clog2(D + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_i,
  input logic          done_i,
  input logic          disp_valid_o,
  input logic          disp_ready_i,
  input logic [AW-1:0] disp_addr_o,
  input logic          run_o,
  input logic [CW-1:0] fill,
  input logic [D-1:0]  pend
);
  a_r2_load_queues: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !pend[NSRC]) |=> pend[NSRC]);

  a_r4_one_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) == $countones(pend));

  a_r6_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && !disp_ready_i) |=> (disp_valid_o && $stable(disp_addr_o)));

  a_r6_pop_starts_run: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && disp_ready_i) |=> run_o);

  a_r7_run_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !done_i) |=> run_o);

  a_r7_done_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && done_i) |=> !run_o);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(D));
endmodule

bind evq_dispatch evq_dispatch_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .done_i(done_i),
  .disp_valid_o(disp_valid_o), .disp_ready_i(disp_ready_i),
  .disp_addr_o(disp_addr_o), .run_o(run_o), .fill(fill), .pend(pend)
);

// File: tb/evq_dispatch_tb.sv
`timescale 1ns/1ps
module evq_dispatch_tb;
  localparam int NSRC = 4;
  localparam int AW   = 12;
  localparam int NROW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] evt = '0;
  logic vec_we = 1'b0, arm = 1'b0, arm_keep = 1'b0;
  logic [1:0] vec_sel = '0, arm_sel = '0;
  logic [AW-1:0] vec_data = '0;
  logic load = 1'b0, rreq = 1'b0, done = 1'b0, rdy = 1'b0;
  logic [AW-1:0] boot = 12'h040;
  logic dv, run;
  logic [AW-1:0] daddr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  evq_dispatch #(.NSRC(NSRC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .vec_we_i(vec_we),
    .vec_sel_i(vec_sel), .vec_data_i(vec_data), .arm_i(arm),
    .arm_sel_i(arm_sel), .arm_keep_i(arm_keep), .load_i(load),
    .rst_req_i(rreq), .boot_addr_i(boot), .done_i(done),
    .disp_valid_o(dv), .disp_ready_i(rdy), .disp_addr_o(daddr), .run_o(run)
  );

  // Row: evt[25:22] ld[21] rq[20] done[19] rdy[18] exp_valid[17] exp_run[16] exp_addr[15:4] tag[3:0]
  localparam logic [25:0] TBL [NROW] = '{
    {4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h040, 4'd2},
    {4'b0110, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h040, 4'd5},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 4'd7},
    {4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 4'd4},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h110, 4'd5},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 12'h120, 4'd7},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h100, 4'd9},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 4'd8},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h100, 4'd8},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 4'd7},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 4'd7},
    {4'b1111, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h100, 4'd5},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h130, 4'd5},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'h040, 4'd2},
    {4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 12'h000, 4'd6},
    {4'b0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 4'd7}
  };

  function automatic string tag_name(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic ev, input logic er,
                         input logic [AW-1:0] ea);
    chk(tag, "disp_valid", 32'(dv), 32'(ev));
    chk(tag, "run", 32'(run), 32'(er));
    if (ev) chk(tag, "disp_addr", 32'(daddr), 32'(ea));
  endtask

  task automatic step(input logic [3:0] e, input logic l, input logic r,
                      input logic d, input logic y);
    evt = e; load = l; rreq = r; done = d; rdy = y;
    @(posedge clk); #5;
    evt = '0; load = 1'b0; rreq = 1'b0; done = 1'b0; rdy = 1'b0;
  endtask

  task automatic wr_vec(input logic [1:0] s, input logic [AW-1:0] v);
    vec_we = 1'b1; vec_sel = s; vec_data = v;
    @(posedge clk); #5;
    vec_we = 1'b0;
  endtask

  task automatic arm_src(input logic [1:0] s, input logic k);
    arm = 1'b1; arm_sel = s; arm_keep = k;
    @(posedge clk); #5;
    arm = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] order [5];
    repeat (3) @(posedge clk);
    #5;
    chk_out("R1", 1'b0, 1'b0, '0);  // R1: idle after reset
    rst_n = 1'b1;
    for (int s = 0; s < NSRC; s++) wr_vec(2'(s), 12'h100 + 12'(s * 16));
    arm_src(2'd0, 1'b1);
    arm_src(2'd1, 1'b0);
    arm_src(2'd2, 1'b0);
    arm_src(2'd3, 1'b1);

    for (int i = 0; i < NROW; i++) begin
      step(TBL[i][25:22], TBL[i][21], TBL[i][20], TBL[i][19], TBL[i][18]);
      chk_out(tag_name(TBL[i][3:0]), TBL[i][17], TBL[i][16], TBL[i][15:4]);
    end

    // R3 armed source pushes its vector; R11 queued entry keeps captured vector
    step(4'b0001, 0, 0, 0, 0);
    chk_out("R3", 1'b1, 1'b0, 12'h100);
    wr_vec(2'd0, 12'h1A0);
    chk_out("R11", 1'b1, 1'b0, 12'h100);
    step(4'b0000, 0, 0, 0, 1);
    step(4'b0000, 0, 0, 1, 0);
    chk_out("R3", 1'b0, 1'b0, '0);
    step(4'b0001, 0, 0, 0, 0);
    chk_out("R11", 1'b1, 1'b0, 12'h1A0);
    step(4'b0000, 0, 0, 0, 1);
    step(4'b0000, 0, 0, 1, 0);

    // R10 full queue, R5 same-cycle order
    arm_src(2'd1, 1'b0);
    arm_src(2'd2, 1'b0);
    step(4'b1111, 0, 1, 0, 0);
    chk_out("R10", 1'b1, 1'b0, 12'h1A0);
    order = '{12'h1A0, 12'h110, 12'h120, 12'h130, 12'h040};
    for (int k = 0; k < 5; k++) begin
      step(4'b0000, 0, 0, 0, 1);
      chk("R6", "run after pop", 32'(run), 32'd1);
      step(4'b0000, 0, 0, 1, 0);
      if (k < 4) chk_out("R5", 1'b1, 1'b0, order[k+1]);
      else       chk_out("R10", 1'b0, 1'b0, '0);
    end

    // R9 one-shot vs keep
    step(4'b0010, 0, 0, 0, 0);
    chk_out("R9", 1'b0, 1'b0, '0);
    step(4'b1000, 0, 0, 0, 0);
    chk_out("R9", 1'b1, 1'b0, 12'h130);

    // R1 reset with a queued entry, then sources disarmed
    rst_n = 1'b0;
    step(4'b0000, 0, 0, 0, 0);
    chk_out("R1", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    step(4'b1001, 0, 0, 0, 0);
    chk_out("R1", 1'b0, 1'b0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule